// File: doc/BRIEF.md
# Single-Bank Row-Buffer Command Sequencer

This block sits between a request queue and one DRAM bank. It takes one read or write request at a time, each giving a row and a column. It keeps track of whether a row is latched in the bank's row buffer and which row that is. From that it works out the command sequence the request needs and sends the commands one by one on a valid/ready command port. The command codes are activate, read, write and precharge.

Two row-buffer policies are available, and a configuration bit picks between them. With the open policy, the row stays latched after an access. With the closed policy, the bank is precharged after each access. The one exception is when the queue's lookahead shows that the next buffered request targets the same row. The block also enforces three programmable spacings, counted in clock cycles: the gap between two activates, the gap between an activate and a column command, and the gap between a write and a following read.

For every accepted request, the block reports on three one-cycle flags whether it was a hit, a miss (no row latched) or a conflict (another row latched).

Top module: `bank_seq_top`

## Requirements
- R1: After reset no row is latched, `reqReady` is high, `cmdValid` is low and no report flag is set; the first request is therefore reported as a miss and its sequence starts with an activate.
- R2: Under the open policy (`cfgClosedRow`=0), a request to the latched row produces only its column command and is reported as a hit.
- R3: A request while no row is latched produces an activate of the requested row, then the column command, and is reported as a miss.
- R4: A request to a row other than the latched one produces a precharge, an activate of the new row and the column command, in that order, and is reported as a conflict.
- R5: Every accepted request raises exactly one of `respHit`, `respMiss`, `respConflict`, for one cycle, in the cycle right after the request handshake.
- R6: Two activate handshakes are at least `cfgTrc` cycles apart.
- R7: A column command is never offered earlier than `cfgTrcd` cycles after the activate handshake. When nothing else holds it back, it is offered in exactly that cycle.
- R8: A read handshake comes at least `cfgTwtr` cycles after the preceding write handshake.
- R9: Under the closed policy (`cfgClosedRow`=1), a precharge follows the column command unless the lookahead (`pendValid`, `pendRow`) names the same row at the column handshake.
- R10: Under the closed policy, when the lookahead matches the row at the column handshake, no precharge is sent and the next request to that row is a hit.
- R11: While `cmdValid` is high and `cmdReady` is low, the command, row and column hold steady. `reqReady` stays low from the handshake of a request until its last command has been accepted.
- R12: The command code on `cmdKind` is 0 for activate, 1 for read, 2 for write and 3 for precharge. `cmdRow` carries the request row on an activate, and `cmdCol` carries the request column on a read or write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgClosedRow | input | 1 | 1 selects the closed-row policy, 0 the open-row policy |
| cfgTrc | input | CNT_W | Minimum cycles between activates |
| cfgTrcd | input | CNT_W | Minimum cycles from activate to column command |
| cfgTwtr | input | CNT_W | Minimum cycles from write to read |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Sequencer can take a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqRow | input | ROW_W | Requested row |
| reqCol | input | COL_W | Requested column |
| pendValid | input | 1 | Lookahead: another request is buffered |
| pendRow | input | ROW_W | Lookahead: row of the buffered request |
| cmdValid | output | 1 | Command offered |
| cmdReady | input | 1 | Bank side accepts the command |
| cmdKind | output | 2 | Command code (see R12) |
| cmdRow | output | ROW_W | Row of the current request |
| cmdCol | output | COL_W | Column of the current request |
| respHit | output | 1 | Request classified as row hit |
| respMiss | output | 1 | Request classified as miss (bank closed) |
| respConflict | output | 1 | Request classified as conflict (other row latched) |

## Verification
The report flag is due in the cycle after the request handshake. The bench samples it on the falling edge that follows that rising edge. The first command of a sequence is offered in that same cycle, provided the activate spacing allows it. A column command after an activate comes exactly `cfgTrcd` cycles after the activate handshake, so the bench checks that gap for equality. The activate-to-activate and write-to-read gaps are checked as lower bounds, measured from cycle stamps that a falling-edge monitor records for every command handshake. Each task waits for `reqReady` to return before it compares the command log, which keeps each sequence's count and order separate from the next.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic doAct;
    logic doPre;
    logic doCol;
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic inOpen;
    logic inMatch;
    logic isWrite;
    logic trcOk;
    logic trcdOk;
    logic wtrOk;
    logic keepOpen;
  } status_t;

endpackage

// File: rtl/bank_seq_dp.sv
module bank_seq_dp
  import bank_seq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             reqWrite,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic             pendValid,
  input  logic [ROW_W-1:0] pendRow,
  input  logic [CNT_W-1:0] cfgTrc,
  input  logic [CNT_W-1:0] cfgTrcd,
  input  logic [CNT_W-1:0] cfgTwtr,
  output status_t          stat,
  output logic [ROW_W-1:0] cmdRow,
  output logic [COL_W-1:0] cmdCol
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ROW_W-1:0] rowQ;
  logic [COL_W-1:0] colQ;
  logic             wrQ;
  logic             openQ;
  logic [ROW_W-1:0] openRowQ;
  logic [CNT_W-1:0] sinceAct;
  logic [CNT_W-1:0] sinceWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ     <= '0;
      colQ     <= '0;
      wrQ      <= 1'b0;
      openQ    <= 1'b0;
      openRowQ <= '0;
      sinceAct <= CNT_MAX;
      sinceWr  <= CNT_MAX;
    end else begin
      if (strb.latchReq) begin
        rowQ <= reqRow;
        colQ <= reqCol;
        wrQ  <= reqWrite;
      end
      if (strb.doAct) begin
        openQ    <= 1'b1;
        openRowQ <= rowQ;
        sinceAct <= CNT_ONE;
      end else if (sinceAct != CNT_MAX) begin
        sinceAct <= sinceAct + CNT_ONE;
      end
      if (strb.doPre) openQ <= 1'b0;
      if (strb.doCol && wrQ) begin
        sinceWr <= CNT_ONE;
      end else if (sinceWr != CNT_MAX) begin
        sinceWr <= sinceWr + CNT_ONE;
      end
    end
  end

  always_comb begin
    stat.inOpen   = openQ;
    stat.inMatch  = (openRowQ == reqRow);
    stat.isWrite  = wrQ;
    stat.trcOk    = (sinceAct >= cfgTrc);
    stat.trcdOk   = (sinceAct >= cfgTrcd);
    stat.wtrOk    = (sinceWr >= cfgTwtr);
    stat.keepOpen = pendValid && (pendRow == rowQ);
  end

  assign cmdRow = rowQ;
  assign cmdCol = colQ;

endmodule

// File: rtl/bank_seq_ctrl.sv
module bank_seq_ctrl
  import bank_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgClosedRow,
  input  logic    reqValid,
  output logic    reqReady,
  output logic    cmdValid,
  input  logic    cmdReady,
  output cmd_e    cmdKind,
  input  status_t stat,
  output strobe_t strb,
  output logic    respHit,
  output logic    respMiss,
  output logic    respConflict
);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_ACT, S_COL, S_CLOSE
  } state_e;

  state_e state, nextState;
  logic   fire;

  always_comb begin
    reqReady  = 1'b0;
    cmdValid  = 1'b0;
    cmdKind   = CMD_ACT;
    strb      = '0;
    nextState = state;
    fire      = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady      = 1'b1;
        strb.latchReq = reqValid;
        if (reqValid) begin
          if (!stat.inOpen)     nextState = S_ACT;
          else if (stat.inMatch) nextState = S_COL;
          else                   nextState = S_PRE;
        end
      end
      S_PRE, S_CLOSE: begin
        cmdValid   = 1'b1;
        cmdKind    = CMD_PRE;
        fire       = cmdReady;
        strb.doPre = fire;
        if (fire) nextState = (state == S_PRE) ? S_ACT : S_IDLE;
      end
      S_ACT: begin
        cmdValid   = stat.trcOk;
        cmdKind    = CMD_ACT;
        fire       = cmdValid && cmdReady;
        strb.doAct = fire;
        if (fire) nextState = S_COL;
      end
      S_COL: begin
        cmdValid   = stat.trcdOk && (stat.isWrite || stat.wtrOk);
        cmdKind    = stat.isWrite ? CMD_WR : CMD_RD;
        fire       = cmdValid && cmdReady;
        strb.doCol = fire;
        if (fire) nextState = (cfgClosedRow && !stat.keepOpen) ? S_CLOSE : S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      respHit      <= 1'b0;
      respMiss     <= 1'b0;
      respConflict <= 1'b0;
    end else begin
      state        <= nextState;
      respHit      <= strb.latchReq && stat.inOpen && stat.inMatch;
      respMiss     <= strb.latchReq && !stat.inOpen;
      respConflict <= strb.latchReq && stat.inOpen && !stat.inMatch;
    end
  end

endmodule

// File: rtl/bank_seq_top.sv
module bank_seq_top
  import bank_seq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgClosedRow,
  input  logic [CNT_W-1:0] cfgTrc,
  input  logic [CNT_W-1:0] cfgTrcd,
  input  logic [CNT_W-1:0] cfgTwtr,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic [ROW_W-1:0] reqRow,
  input  logic [COL_W-1:0] reqCol,
  input  logic             pendValid,
  input  logic [ROW_W-1:0] pendRow,
  output logic             cmdValid,
  input  logic             cmdReady,
  output logic [1:0]       cmdKind,
  output logic [ROW_W-1:0] cmdRow,
  output logic [COL_W-1:0] cmdCol,
  output logic             respHit,
  output logic             respMiss,
  output logic             respConflict
);

  strobe_t strb;
  status_t stat;
  cmd_e    kind;

  bank_seq_ctrl u_ctrl (
    .clk, .rstN, .cfgClosedRow, .reqValid, .reqReady,
    .cmdValid, .cmdReady, .cmdKind(kind), .stat, .strb,
    .respHit, .respMiss, .respConflict
  );

  bank_seq_dp #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_dp (
    .clk, .rstN, .strb, .reqWrite, .reqRow, .reqCol, .pendValid, .pendRow,
    .cfgTrc, .cfgTrcd, .cfgTwtr, .stat, .cmdRow, .cmdCol
  );

  assign cmdKind = kind;

endmodule

// File: rtl/bank_seq_chk.sv
module bank_seq_chk #(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] cfgTrc,
  input logic [CNT_W-1:0] cfgTrcd,
  input logic [CNT_W-1:0] cfgTwtr,
  input logic             reqReady,
  input logic             cmdValid,
  input logic             cmdReady,
  input logic [1:0]       cmdKind,
  input logic [ROW_W-1:0] cmdRow,
  input logic [COL_W-1:0] cmdCol,
  input logic             respHit,
  input logic             respMiss,
  input logic             respConflict
);

  localparam logic [CNT_W-1:0] SAT = '1;

  logic             shOpen;
  logic [ROW_W-1:0] shRow;
  logic [CNT_W-1:0] shAct;
  logic [CNT_W-1:0] shWr;
  logic             isAct, isCol, isRd, isWr, isPre;

  assign isAct = cmdValid && cmdReady && (cmdKind == 2'd0);
  assign isRd  = cmdValid && cmdReady && (cmdKind == 2'd1);
  assign isWr  = cmdValid && cmdReady && (cmdKind == 2'd2);
  assign isPre = cmdValid && cmdReady && (cmdKind == 2'd3);
  assign isCol = isRd || isWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shOpen <= 1'b0;
      shRow  <= '0;
      shAct  <= SAT;
      shWr   <= SAT;
    end else begin
      if (isAct) begin
        shOpen <= 1'b1;
        shRow  <= cmdRow;
      end
      if (isPre) shOpen <= 1'b0;
      shAct <= isAct ? CNT_W'(1) : ((shAct == SAT) ? SAT : shAct + CNT_W'(1));
      shWr  <= isWr  ? CNT_W'(1) : ((shWr  == SAT) ? SAT : shWr  + CNT_W'(1));
    end
  end

  // R3
  act_closed_chk: assert property (@(posedge clk) disable iff (!rstN) isAct |-> !shOpen);
  // R4
  pre_open_chk: assert property (@(posedge clk) disable iff (!rstN) isPre |-> shOpen);
  // R2
  col_open_chk: assert property (@(posedge clk) disable iff (!rstN) isCol |-> (shOpen && cmdRow == shRow));
  // R6
  trc_gap_chk: assert property (@(posedge clk) disable iff (!rstN) isAct |-> (shAct >= cfgTrc));
  // R7
  trcd_gap_chk: assert property (@(posedge clk) disable iff (!rstN) isCol |-> (shAct >= cfgTrcd));
  // R8
  wtr_gap_chk: assert property (@(posedge clk) disable iff (!rstN) isRd |-> (shWr >= cfgTwtr));
  // R5
  resp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0({respHit, respMiss, respConflict}));
  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdKind) && $stable(cmdRow) && $stable(cmdCol)));
  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rstN) reqReady |-> !cmdValid);

endmodule

bind bank_seq_top bank_seq_chk #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgTrc(cfgTrc), .cfgTrcd(cfgTrcd), .cfgTwtr(cfgTwtr),
  .reqReady(reqReady), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdKind(cmdKind),
  .cmdRow(cmdRow), .cmdCol(cmdCol), .respHit(respHit), .respMiss(respMiss),
  .respConflict(respConflict)
);

// File: tb/tb_bank_seq_top.sv
`timescale 1ns/1ps
module tb_bank_seq_top;

  localparam int ROW_W = 14;
  localparam int COL_W = 10;
  localparam int CNT_W = 6;
  localparam int K_ACT = 0, K_RD = 1, K_WR = 2, K_PRE = 3;
  localparam int C_HIT = 0, C_MISS = 1, C_CONF = 2;
  localparam int TRC = 10, TRCD = 3, TWTR = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgClosedRow = 1'b0;
  logic [CNT_W-1:0] cfgTrc = CNT_W'(TRC);
  logic [CNT_W-1:0] cfgTrcd = CNT_W'(TRCD);
  logic [CNT_W-1:0] cfgTwtr = CNT_W'(TWTR);
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic             reqWrite = 1'b0;
  logic [ROW_W-1:0] reqRow = '0;
  logic [COL_W-1:0] reqCol = '0;
  logic             pendValid = 1'b0;
  logic [ROW_W-1:0] pendRow = '0;
  logic             cmdValid;
  logic             cmdReady = 1'b1;
  logic [1:0]       cmdKind;
  logic [ROW_W-1:0] cmdRow;
  logic [COL_W-1:0] cmdCol;
  logic             respHit, respMiss, respConflict;

  bank_seq_top #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) dut (
    .clk, .rstN, .cfgClosedRow, .cfgTrc, .cfgTrcd, .cfgTwtr,
    .reqValid, .reqReady, .reqWrite, .reqRow, .reqCol, .pendValid, .pendRow,
    .cmdValid, .cmdReady, .cmdKind, .cmdRow, .cmdCol,
    .respHit, .respMiss, .respConflict
  );

  always #2 clk = ~clk;

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int cmdN = 0;
  int respN = 0;
  int logKind [64];
  int logRow [64];
  int logCol [64];
  int logCyc [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN) begin
      if (cmdValid && cmdReady && cmdN < 64) begin
        logKind[cmdN] = int'(cmdKind);
        logRow[cmdN]  = int'(cmdRow);
        logCol[cmdN]  = int'(cmdCol);
        logCyc[cmdN]  = cyc;
        cmdN = cmdN + 1;
      end
      if (respHit || respMiss || respConflict) respN = respN + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expCmd(input int idx, input int kind, input int row, input int col, input string tag);
    check(logKind[idx] == kind, {tag, " kind"}, logKind[idx], kind);
    if (row >= 0) check(logRow[idx] == row, {tag, " row"}, logRow[idx], row);
    if (col >= 0) check(logCol[idx] == col, {tag, " col"}, logCol[idx], col);
  endtask

  // issues one request, checks its report flag, waits until idle
  task automatic doReq(input bit wr, input int row, input int col, input int expCls, input string tag);
    int r0 = respN;
    int guard = 0;
    int got;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr;
    reqRow = ROW_W'(row); reqCol = COL_W'(col);
    while (!reqReady && guard < 200) begin @(negedge clk); guard++; end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    got = respHit ? C_HIT : respMiss ? C_MISS : respConflict ? C_CONF : 3;
    check(got == expCls, {tag, " R5 report class"}, got, expCls);
    guard = 0;
    while (!reqReady && guard < 200) begin @(negedge clk); guard++; end
    @(negedge clk);
    check(respN == r0 + 1, {tag, " R5 single report"}, respN - r0, 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(cmdValid == 1'b0, "R1 cmdValid in reset", int'(cmdValid), 0);
    check(reqReady == 1'b1, "R1 reqReady in reset", int'(reqReady), 1);
    check({respHit, respMiss, respConflict} == 3'b000, "R1 flags in reset",
          int'({respHit, respMiss, respConflict}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(cmdValid == 1'b0 && reqReady == 1'b1, "R1 idle after reset",
          int'({cmdValid, reqReady}), 1);
  endtask

  int firstAct;

  task automatic testFirstMiss();
    int b = cmdN;
    doReq(1'b0, 5, 7, C_MISS, "R1 R3 first read");
    check(cmdN - b == 2, "R3 command count", cmdN - b, 2);
    expCmd(b, K_ACT, 5, -1, "R3 R12 activate");
    expCmd(b + 1, K_RD, -1, 7, "R3 R12 read");
    check(logCyc[b + 1] - logCyc[b] == TRCD, "R7 act-to-read gap",
          logCyc[b + 1] - logCyc[b], TRCD);
    firstAct = logCyc[b];
  endtask

  task automatic testHit();
    int b = cmdN;
    doReq(1'b0, 5, 8, C_HIT, "R2 hit");
    check(cmdN - b == 1, "R2 column only", cmdN - b, 1);
    expCmd(b, K_RD, -1, 8, "R2 read");
  endtask

  int lastWr;

  task automatic testConflict();
    int b = cmdN;
    doReq(1'b1, 12, 2, C_CONF, "R4 conflict");
    check(cmdN - b == 3, "R4 command count", cmdN - b, 3);
    expCmd(b, K_PRE, -1, -1, "R4 precharge");
    expCmd(b + 1, K_ACT, 12, -1, "R4 activate");
    expCmd(b + 2, K_WR, -1, 2, "R4 R12 write");
    check(logCyc[b + 1] - firstAct >= TRC, "R6 act-to-act gap",
          logCyc[b + 1] - firstAct, TRC);
    check(logCyc[b + 2] - logCyc[b + 1] == TRCD, "R7 act-to-write gap",
          logCyc[b + 2] - logCyc[b + 1], TRCD);
    lastWr = logCyc[b + 2];
  endtask

  task automatic testWtr();
    int b = cmdN;
    doReq(1'b0, 12, 4, C_HIT, "R8 read after write");
    check(cmdN - b == 1, "R8 command count", cmdN - b, 1);
    expCmd(b, K_RD, -1, 4, "R8 read");
    check(logCyc[b] - lastWr >= TWTR, "R8 write-to-read gap", logCyc[b] - lastWr, TWTR);
  endtask

  task automatic testClosedNoMatch();
    int b;
    cfgClosedRow = 1'b1;
    pendValid = 1'b0;
    b = cmdN;
    doReq(1'b0, 12, 1, C_HIT, "R9 closed hit");
    check(cmdN - b == 2, "R9 command count", cmdN - b, 2);
    expCmd(b, K_RD, -1, 1, "R9 read");
    expCmd(b + 1, K_PRE, -1, -1, "R9 auto precharge");
    b = cmdN;
    doReq(1'b0, 3, 5, C_MISS, "R9 closed miss");
    check(cmdN - b == 3, "R9 miss count", cmdN - b, 3);
    expCmd(b, K_ACT, 3, -1, "R9 activate");
    expCmd(b + 1, K_RD, -1, 5, "R9 read2");
    expCmd(b + 2, K_PRE, -1, -1, "R9 precharge2");
  endtask

  task automatic testClosedMatch();
    int b;
    pendValid = 1'b1;
    pendRow = ROW_W'(3);
    b = cmdN;
    doReq(1'b1, 3, 9, C_MISS, "R10 lookahead");
    check(cmdN - b == 2, "R10 no precharge", cmdN - b, 2);
    expCmd(b, K_ACT, 3, -1, "R10 activate");
    expCmd(b + 1, K_WR, -1, 9, "R10 write");
    pendValid = 1'b0;
    b = cmdN;
    doReq(1'b0, 3, 6, C_HIT, "R10 follow-up hit");
    check(cmdN - b == 2, "R10 follow-up count", cmdN - b, 2);
    expCmd(b, K_RD, -1, 6, "R10 read");
    expCmd(b + 1, K_PRE, -1, -1, "R10 precharge");
    cfgClosedRow = 1'b0;
  endtask

  task automatic testBackpressure();
    int b = cmdN;
    cmdReady = 1'b0;
    fork
      doReq(1'b0, 20, 11, C_MISS, "R11 stall");
      begin
        repeat (5) @(negedge clk);
        check(cmdValid == 1'b1, "R11 valid held", int'(cmdValid), 1);
        check(int'(cmdKind) == K_ACT, "R11 kind held", int'(cmdKind), K_ACT);
        check(int'(cmdRow) == 20, "R11 row held", int'(cmdRow), 20);
        check(reqReady == 1'b0, "R11 busy", int'(reqReady), 0);
        cmdReady = 1'b1;
      end
    join
    check(cmdN - b == 2, "R11 command count", cmdN - b, 2);
    expCmd(b, K_ACT, 20, -1, "R11 activate");
    expCmd(b + 1, K_RD, -1, 11, "R11 read");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testFirstMiss();
    testHit();
    testConflict();
    testWtr();
    testClosedNoMatch();
    testClosedMatch();
    testBackpressure();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule